// File: doc/BRIEF.md
# Instruction Byte-Pair Write Assembler

This block builds 16-bit instruction words out of a stream of 8-bit remote accesses to instruction memory. A word always arrives as two bytes, the low byte first and then the high byte. A one-bit high-byte flag records which half the next access refers to. A low-byte write only lands in a hidden holding register. The following high-byte write presents the whole word to instruction memory as one write: the new byte on bits 15:8 and the held byte on bits 7:0. At the same moment the write strobe rises.

Each access opens with a one-cycle request strobe and closes with a one-cycle completion pulse from the wait-state logic outside the block. The write strobe stays up from the request until the completion pulse, so it covers whatever instruction-memory wait states are programmed. Every completed access toggles the flag, whether it is a read or a write. A completed high-byte access also advances the program counter, which wraps at its top value.

On reads, the flag picks which byte of the addressed memory word is returned. Software can put the word boundary back in step without a reset by writing the instruction-memory code into the memory-select field. That write clears the flag.

Top module: `ibyte_pair_asm`

## Requirements
- R1: During and directly after synchronous reset: `hi_flag`=0, `pc`=0, `wr_strobe`=0 and `wr_word`=0.
- R2: A write request (`acc_valid`=1, `acc_write`=1) accepted while `hi_flag`=0 stores `acc_data` in the holding register only. `wr_strobe` stays 0 and `wr_word` keeps its value.
- R3: A write request accepted while `hi_flag`=1 makes `wr_word` = {`acc_data`, held byte} (new byte on bits 15:8) and raises `wr_strobe` on the clock edge that accepts the request.
- R4: `wr_strobe` stays 1 on every cycle until the completion pulse `acc_done` and falls on that same edge.
- R5: Each completed access, read or write, toggles `hi_flag` on the edge that sees `acc_done`.
- R6: `pc` increases by one on completion of an access that began with `hi_flag`=1. It is unchanged after a low-byte access.
- R7: `pc` is PC_W bits wide (default 16) and wraps from its all-ones value to 0.
- R8: A memory-select write (`msel_wr`=1) with `msel_val`=2'b01 clears `hi_flag` on the next edge, and this wins over a toggle on the same edge. Other `msel_val` codes leave the flag alone.
- R9: `rd_byte` equals `mem_rdata[7:0]` when `hi_flag`=0 and `mem_rdata[15:8]` when `hi_flag`=1, with no delay.
- R10: A request that arrives while an access is open is ignored. A completion pulse that arrives while no access is open is ignored.
- R11: A read access (`acc_write`=0) never raises `wr_strobe` and leaves the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle request that opens a byte access |
| acc_write | input | 1 | 1 = write, 0 = read (sampled with acc_valid) |
| acc_data | input | BYTE_W | Byte written by the remote side |
| acc_done | input | 1 | One-cycle completion pulse of the open access |
| msel_wr | input | 1 | Write strobe of the memory-select field |
| msel_val | input | MSEL_W | Value written to the memory-select field |
| mem_rdata | input | 2*BYTE_W | Addressed instruction word, for reads |
| wr_word | output | 2*BYTE_W | Word presented to instruction memory |
| wr_strobe | output | 1 | Instruction-memory write strobe |
| hi_flag | output | 1 | 1 = high byte expected next |
| pc | output | PC_W | Program counter |
| rd_byte | output | BYTE_W | Byte returned on reads |

## Verification
`wr_word` and a rising `wr_strobe` appear one edge after the request. `hi_flag`, a falling `wr_strobe` and `pc` settle one edge after `acc_done` or the memory-select write. `rd_byte` follows `hi_flag` and `mem_rdata` within the same cycle. The driver applies each stimulus on the falling edge. It then waits for the next rising edge plus 1 ns, works out from the requirements what every output should hold after that one edge, and queues it. A monitor compares the queued values with the outputs at that sample point, so each result is checked in exactly the cycle it is due. The program-counter wrap is reached by running the bench instance with an 8-bit counter.

// File: rtl/ibpa_pkg.sv
package ibpa_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_OPEN = 1'b1
    } phase_e;

    typedef struct packed {
        logic is_write;
        logic is_high;
    } acc_info_t;

    localparam logic [1:0] MSEL_IMEM = 2'b01;

    function automatic logic is_imem_select(input logic [1:0] code);
        return code == MSEL_IMEM;
    endfunction

endpackage

// File: rtl/ibpa_flag.sv
module ibpa_flag (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    input  logic force_low,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (force_low) begin
            flag <= 1'b0;
        end else if (toggle) begin
            flag <= ~flag;
        end
    end

    // R8: resync wins over everything else
    assert_force_clears_R8: assert property (@(posedge clk) disable iff (rst)
        force_low |=> !flag);
endmodule

// File: rtl/ibpa_word.sv
module ibpa_word #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_write,
    input  logic              start_high,
    input  logic [BYTE_W-1:0] din,
    input  logic              finish,
    output logic [WORD_W-1:0] word,
    output logic              strobe
);
    logic [BYTE_W-1:0] hold_q;
    logic              cap_low;
    logic              cap_high;

    always_comb begin
        cap_low  = start && start_write && !start_high;
        cap_high = start && start_write && start_high;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            word   <= '0;
            strobe <= 1'b0;
        end else begin
            if (cap_low) begin
                hold_q <= din;
            end
            if (cap_high) begin
                word   <= {din, hold_q};
                strobe <= 1'b1;
            end else if (finish) begin
                strobe <= 1'b0;
            end
        end
    end

    // R2: low byte produces no memory write
    assert_low_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        cap_low |=> (!strobe && $stable(word)));
    // R3: high byte lands on the upper half
    assert_high_upper_R3: assert property (@(posedge clk) disable iff (rst)
        cap_high |=> (strobe && word[WORD_W-1:BYTE_W] == $past(din)));
    // R11: a read leaves the holding register alone
    assert_read_keeps_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !start_write) |=> $stable(hold_q));
endmodule

// File: rtl/ibpa_pc.sv
module ibpa_pc #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    output logic [PC_W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (step) begin
            pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/ibyte_pair_asm.sv
module ibyte_pair_asm
    import ibpa_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PC_W   = 16,
    parameter int MSEL_W = 2,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BYTE_W-1:0] acc_data,
    input  logic              acc_done,
    input  logic              msel_wr,
    input  logic [MSEL_W-1:0] msel_val,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] wr_word,
    output logic              wr_strobe,
    output logic              hi_flag,
    output logic [PC_W-1:0]   pc,
    output logic [BYTE_W-1:0] rd_byte
);
    phase_e    phase_q;
    acc_info_t cur_q;
    logic      start;
    logic      finish;
    logic      resync;

    always_comb begin
        start  = (phase_q == PH_IDLE) && acc_valid;
        finish = (phase_q == PH_OPEN) && acc_done;
        resync = msel_wr && is_imem_select(msel_val[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cur_q   <= '0;
        end else if (start) begin
            phase_q        <= PH_OPEN;
            cur_q.is_write <= acc_write;
            cur_q.is_high  <= hi_flag;
        end else if (finish) begin
            phase_q <= PH_IDLE;
        end
    end

    ibpa_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .toggle   (finish),
        .force_low(resync),
        .flag     (hi_flag)
    );

    ibpa_word #(.BYTE_W(BYTE_W)) u_word (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_write(acc_write),
        .start_high (hi_flag),
        .din        (acc_data),
        .finish     (finish),
        .word       (wr_word),
        .strobe     (wr_strobe)
    );

    ibpa_pc #(.PC_W(PC_W)) u_pc (
        .clk (clk),
        .rst (rst),
        .step(finish && cur_q.is_high),
        .pc  (pc)
    );

    always_comb begin
        rd_byte = hi_flag ? mem_rdata[WORD_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
    end

    // R4: strobe only while an access is open
    assert_strobe_in_access_R4: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (phase_q == PH_OPEN));
    // R5: each completion flips the flag unless resync
    assert_flag_flips_R5: assert property (@(posedge clk) disable iff (rst)
        (finish && !resync) |=> (hi_flag != $past(hi_flag)));
    // R6: pc follows completed high-byte accesses only
    assert_pc_steps_R6: assert property (@(posedge clk) disable iff (rst)
        (finish && cur_q.is_high) |=> (pc == PC_W'($past(pc) + 1'b1)));
    assert_pc_holds_R6: assert property (@(posedge clk) disable iff (rst)
        !(finish && cur_q.is_high) |=> $stable(pc));
    // R10: new request ignored while open
    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_OPEN) && !acc_done) |=> (phase_q == PH_OPEN));
endmodule

// File: tb/test_ibyte_pair_asm.sv
module test_ibyte_pair_asm;
    localparam int TPW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_done = 1'b0, msel_wr = 1'b0;
    logic [7:0]  acc_data = '0;
    logic [1:0]  msel_val = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] wr_word;
    logic        wr_strobe, hi_flag;
    logic [TPW-1:0] pc;
    logic [7:0]  rd_byte;

    ibyte_pair_asm #(.BYTE_W(8), .PC_W(TPW), .MSEL_W(2)) i_ibyte_pair_asm (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_data(acc_data), .acc_done(acc_done), .msel_wr(msel_wr),
        .msel_val(msel_val), .mem_rdata(mem_rdata), .wr_word(wr_word),
        .wr_strobe(wr_strobe), .hi_flag(hi_flag), .pc(pc), .rd_byte(rd_byte)
    );

    always #5 clk = ~clk;

    typedef struct {
        string          req;
        logic [15:0]    word;
        logic           strobe;
        logic           flag;
        logic [TPW-1:0] pc;
        logic [7:0]     rbyte;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done_all = 0;

    // reference state, built from the requirements
    logic           m_flag = 0, m_strobe = 0, m_busy = 0, m_high = 0;
    logic [7:0]     m_hold = 0;
    logic [15:0]    m_word = 0;
    logic [TPW-1:0] m_pc = 0;

    function automatic logic [7:0] m_rd();
        return m_flag ? mem_rdata[15:8] : mem_rdata[7:0];
    endfunction

    task automatic push(input string req);
        exp_t e;
        e.req = req; e.word = m_word; e.strobe = m_strobe;
        e.flag = m_flag; e.pc = m_pc; e.rbyte = m_rd();
        q.push_back(e);
    endtask

    task automatic tick(input logic v, input logic w, input logic [7:0] d,
                        input logic dn, input logic mw, input logic [1:0] mv,
                        input string req);
        logic frc;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_data = d; acc_done = dn;
        msel_wr = mw; msel_val = mv;
        @(posedge clk);
        frc = mw && (mv == 2'b01);
        if (!m_busy && v) begin
            m_busy = 1; m_high = m_flag;
            if (w && !m_flag) m_hold = d;
            if (w && m_flag) begin m_word = {d, m_hold}; m_strobe = 1; end
        end else if (m_busy && dn) begin
            m_busy = 0; m_strobe = 0;
            if (!frc) m_flag = !m_flag;
            if (m_high) m_pc = m_pc + 1'b1;
        end
        if (frc) m_flag = 0;
        #1;
        push(req);
        @(negedge clk);
        acc_valid = 0; acc_done = 0; msel_wr = 0;
    endtask

    task automatic idle(input string req);
        tick(0, 0, 8'h00, 0, 0, 2'b00, req);
    endtask

    // monitor: pops expected items and compares
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (wr_word !== e.word || wr_strobe !== e.strobe || hi_flag !== e.flag ||
                    pc !== e.pc || rd_byte !== e.rbyte) begin
                    bad++;
                    $display("FAIL %s: got word=%h stb=%b flag=%b pc=%h rd=%h exp word=%h stb=%b flag=%b pc=%h rd=%h",
                             e.req, wr_word, wr_strobe, hi_flag, pc, rd_byte,
                             e.word, e.strobe, e.flag, e.pc, e.rbyte);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done_all) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; push("R1 reset state");
        @(negedge clk); rst = 0;
        idle("R1 after reset");

        // low byte then high byte
        tick(1, 1, 8'h34, 0, 0, 2'b00, "R2 low byte held only");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R5 flag toggles after low");
        tick(1, 1, 8'h12, 0, 0, 2'b00, "R3 word assembled");
        idle("R4 strobe held");
        idle("R4 strobe held 2");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R6 pc steps after high");

        // reads
        mem_rdata = 16'hABCD;
        idle("R9 low byte returned");
        tick(1, 0, 8'hEE, 0, 0, 2'b00, "R11 read no strobe");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R5 flag toggles after read");
        mem_rdata = 16'h5AA5;
        idle("R9 high byte returned");
        tick(1, 0, 8'h77, 0, 0, 2'b00, "R11 read high");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R6 pc steps after high read");

        // busy ignores second request
        tick(1, 1, 8'h56, 0, 0, 2'b00, "R2 low byte 56");
        tick(1, 1, 8'h99, 0, 0, 2'b00, "R10 request while open ignored");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R10 done closes first");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R10 done while idle ignored");
        tick(1, 1, 8'h78, 0, 0, 2'b00, "R10 word keeps held 56");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R6 pc after word");

        // resync
        tick(1, 1, 8'h11, 0, 0, 2'b00, "R2 low byte 11");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R5 flag high");
        tick(0, 0, 8'h00, 0, 1, 2'b10, "R8 other code no effect");
        tick(0, 0, 8'h00, 0, 1, 2'b01, "R8 imem code clears flag");
        tick(1, 1, 8'h22, 0, 0, 2'b00, "R8 next write is low byte");
        tick(0, 0, 8'h00, 1, 1, 2'b01, "R8 clear wins over toggle");
        tick(1, 1, 8'h33, 0, 0, 2'b00, "R2 low after resync");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R5 toggle");
        tick(1, 1, 8'h44, 0, 0, 2'b00, "R3 word 4433");
        tick(0, 0, 8'h00, 1, 0, 2'b00, "R6 pc step");

        // wrap of the counter
        for (int i = 0; i < (1 << TPW) + 2; i++) begin
            tick(1, 1, 8'(i), 0, 0, 2'b00, "R7 low byte");
            tick(0, 0, 8'h00, 1, 0, 2'b00, "R7 low done");
            tick(1, 1, 8'(i + 1), 0, 0, 2'b00, "R7 high byte");
            tick(0, 0, 8'h00, 1, 0, 2'b00, "R7 pc wraps");
        end

        wait (q.size() == 0);
        #2;
        done_all = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule